// File: doc/BRIEF.md
# DMA Channel Request Enable Gate

This block sits in front of a DMA channel arbiter. It holds one enable bit per channel and decides, every cycle, which channels present a pending service request to the arbiter. Requests come from three sources. Hardware request lines are level signals from peripherals and pass only when the channel's enable bit is set. Software-initiated requests and channel-link requests are single-cycle pulses. They are caught and held regardless of the enable bit.

The enable map can be replaced as a whole through a bus-side write port and is always visible on a read-back port. Two single-channel ports, one that sets and one that clears, change one enable bit (or, with an "all" flag, every bit) without a read-modify-write. The arbiter returns a per-channel acknowledge. The acknowledge retires held software and link requests. It also hides a still-asserted hardware level until that line has dropped, so that one level is not serviced twice.

Top module: `dma_req_gate`

## Requirements
- R1: The block has NUM_CH channels (default 16), and bit n of every channel-indexed vector, the enable map included, belongs to channel n. The enable read-back port shows the map from the cycle after any change to it.
- R2: A full-map write (map_wr_en high) makes the enable map equal to map_wr_data at the next clock edge.
- R3: A set strobe (set_vld) sets the enable bit of channel set_ch and leaves every other bit unchanged. With set_all high, it sets all bits instead.
- R4: A clear strobe (clr_vld) clears the enable bit of channel clr_ch and leaves every other bit unchanged. With clr_all high, it clears all bits instead. When set and clear strobes arrive in the same cycle, the clear is applied after the set, so a clear of the same channel wins.
- R5: When a full-map write and a set or clear strobe arrive in the same cycle, the full write is applied first and the single-bit operations are applied on top of the written value.
- R6: The hardware term of pend[n] is high in the same cycle that hw_req[n] is high, provided the registered enable bit n is 1 and channel n is not suppressed. With enable bit n at 0, hw_req[n] alone never raises pend[n].
- R7: An ack[n] at a clock edge where hw_req[n] is high suppresses the hardware term of channel n from the next cycle onward. The suppression ends once hw_req[n] has been seen low at a clock edge.
- R8: A sw_req[n] pulse makes pend[n] high from the next cycle, whatever the enable bit. pend[n] stays high until ack[n] is seen at a clock edge. A new pulse arriving in the same cycle as the ack keeps the request held.
- R9: A link_req[n] pulse behaves exactly as in R8: it is held regardless of the enable bit until ack[n], and a same-cycle new pulse wins over the ack.
- R10: While rst_n is low, and directly after it is released, the enable map, the held software and link requests and the suppression state are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_wr_en | input | 1 | Full enable-map write strobe |
| map_wr_data | input | NUM_CH | Value written to the enable map |
| map_rd_data | output | NUM_CH | Current enable map |
| set_vld | input | 1 | Single-channel set strobe |
| set_all | input | 1 | With set_vld: set every enable bit |
| set_ch | input | CHW | Channel whose enable bit is set |
| clr_vld | input | 1 | Single-channel clear strobe |
| clr_all | input | 1 | With clr_vld: clear every enable bit |
| clr_ch | input | CHW | Channel whose enable bit is cleared |
| hw_req | input | NUM_CH | Hardware request levels |
| sw_req | input | NUM_CH | Software request pulses |
| link_req | input | NUM_CH | Channel-link request pulses |
| ack | input | NUM_CH | Per-channel service acknowledge from the arbiter |
| pend | output | NUM_CH | Pending requests towards the arbiter |

## Verification
The hardest situations to reach from the ports are coincidences within one cycle. These include a full write together with both a set and a clear, a clear and a set of the same channel, an acknowledge together with a fresh software pulse, and a hardware level that stays up across its acknowledge and then drops and rises again. Directed phases build each of these cases on purpose. A long random phase follows, with independent strobe probabilities and narrow channel ranges, so these collisions keep occurring in all combinations. A behavioural model of the requirements checks the read-back map and the pending vector on every clock.

// File: rtl/dmagate_pkg.sv
package dmagate_pkg;

   // Kind of single-bit operation presented at a set or clear port.
   typedef enum logic [1:0] {
      BOP_NONE = 2'd0,
      BOP_ONE  = 2'd1,
      BOP_ALL  = 2'd2
   } bitop_e;

   // Classify a set/clear port strobe.
   function automatic bitop_e bitop_kind(input logic vld, input logic all);
      if (!vld)      return BOP_NONE;
      else if (all)  return BOP_ALL;
      else           return BOP_ONE;
   endfunction

   // Largest channel count the block is written for.
   localparam int unsigned MAX_CH = 64;

endpackage

// File: rtl/dmagate_enable_map.sv
module dmagate_enable_map
   import dmagate_pkg::*;
#(
   parameter int unsigned NUM_CH = 16,
   parameter int unsigned CHW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [NUM_CH-1:0] wr_data,
   input  logic              set_vld,
   input  logic              set_all,
   input  logic [CHW-1:0]    set_ch,
   input  logic              clr_vld,
   input  logic              clr_all,
   input  logic [CHW-1:0]    clr_ch,
   output logic [NUM_CH-1:0] en
);

   bitop_e            set_kind;
   bitop_e            clr_kind;
   logic [NUM_CH-1:0] set_mask;
   logic [NUM_CH-1:0] clr_mask;
   logic [NUM_CH-1:0] base;
   logic [NUM_CH-1:0] en_nxt;
   logic [NUM_CH-1:0] en_q;

   assign set_kind = bitop_kind(set_vld, set_all);
   assign clr_kind = bitop_kind(clr_vld, clr_all);

   // Per-bit decode of the single-channel ports.
   for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
      always_comb begin
         unique case (set_kind)
            BOP_ALL: set_mask[i] = 1'b1;
            BOP_ONE: set_mask[i] = (set_ch == CHW'(i));
            default: set_mask[i] = 1'b0;
         endcase
         unique case (clr_kind)
            BOP_ALL: clr_mask[i] = 1'b1;
            BOP_ONE: clr_mask[i] = (clr_ch == CHW'(i));
            default: clr_mask[i] = 1'b0;
         endcase
      end
   end

   // Order: full write, then set, then clear.
   always_comb begin
      base   = wr_en ? wr_data : en_q;
      en_nxt = (base | set_mask) & ~clr_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_nxt;
   end

   assign en = en_q;

endmodule

// File: rtl/dmagate_req_latch.sv
module dmagate_req_latch #(
   parameter int unsigned NUM_CH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pulse,
   input  logic [NUM_CH-1:0] ack,
   output logic [NUM_CH-1:0] held
);

   // One sticky flag per channel; a fresh pulse outranks a retiring ack.
   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic held_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        held_q <= 1'b0;
         else if (pulse[i]) held_q <= 1'b1;
         else if (ack[i])   held_q <= 1'b0;
      end
      assign held[i] = held_q;
   end

endmodule

// File: rtl/dmagate_hw_filter.sv
module dmagate_hw_filter #(
   parameter int unsigned NUM_CH   = 16,
   parameter bit          ACK_MASK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] hw_req,
   input  logic [NUM_CH-1:0] en,
   input  logic [NUM_CH-1:0] ack,
   output logic [NUM_CH-1:0] hw_pend,
   output logic [NUM_CH-1:0] masked
);

   if (ACK_MASK) begin : g_mask
      // Suppress an acknowledged level until the line has been seen low.
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         logic m_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          m_q <= 1'b0;
            else if (!hw_req[i]) m_q <= 1'b0;
            else if (ack[i])     m_q <= 1'b1;
         end
         assign masked[i] = m_q;
      end
   end else begin : g_nomask
      // Pure level gating: the source is expected to drop on service.
      logic unused_ok;
      assign unused_ok = ^{clk, rst_n, ack};
      assign masked    = '0;
   end

   assign hw_pend = hw_req & en & ~masked;

endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate
   import dmagate_pkg::*;
#(
   parameter int unsigned NUM_CH   = 16,
   parameter bit          ACK_MASK = 1'b1,
   localparam int unsigned CHW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              map_wr_en,
   input  logic [NUM_CH-1:0] map_wr_data,
   output logic [NUM_CH-1:0] map_rd_data,
   input  logic              set_vld,
   input  logic              set_all,
   input  logic [CHW-1:0]    set_ch,
   input  logic              clr_vld,
   input  logic              clr_all,
   input  logic [CHW-1:0]    clr_ch,
   input  logic [NUM_CH-1:0] hw_req,
   input  logic [NUM_CH-1:0] sw_req,
   input  logic [NUM_CH-1:0] link_req,
   input  logic [NUM_CH-1:0] ack,
   output logic [NUM_CH-1:0] pend
);

   // Elaboration-time parameter checks.
   if (NUM_CH < 2 || NUM_CH > MAX_CH) begin : g_bad_num_ch
      $error("dma_req_gate: NUM_CH must lie between 2 and MAX_CH");
   end

   logic [NUM_CH-1:0] en;
   logic [NUM_CH-1:0] sw_held;
   logic [NUM_CH-1:0] link_held;
   logic [NUM_CH-1:0] hw_pend;
   logic [NUM_CH-1:0] hw_masked;

   dmagate_enable_map #(.NUM_CH(NUM_CH), .CHW(CHW)) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (map_wr_en),
      .wr_data (map_wr_data),
      .set_vld (set_vld),
      .set_all (set_all),
      .set_ch  (set_ch),
      .clr_vld (clr_vld),
      .clr_all (clr_all),
      .clr_ch  (clr_ch),
      .en      (en)
   );

   dmagate_req_latch #(.NUM_CH(NUM_CH)) u_sw (
      .clk   (clk),
      .rst_n (rst_n),
      .pulse (sw_req),
      .ack   (ack),
      .held  (sw_held)
   );

   dmagate_req_latch #(.NUM_CH(NUM_CH)) u_link (
      .clk   (clk),
      .rst_n (rst_n),
      .pulse (link_req),
      .ack   (ack),
      .held  (link_held)
   );

   dmagate_hw_filter #(.NUM_CH(NUM_CH), .ACK_MASK(ACK_MASK)) u_hw (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_req  (hw_req),
      .en      (en),
      .ack     (ack),
      .hw_pend (hw_pend),
      .masked  (hw_masked)
   );

   assign map_rd_data = en;
   assign pend        = hw_pend | sw_held | link_held;

endmodule

// File: rtl/dmagate_chk.sv
module dmagate_chk #(
   parameter int unsigned NUM_CH = 16,
   parameter int unsigned CHW    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              map_wr_en,
   input logic [NUM_CH-1:0] map_wr_data,
   input logic [NUM_CH-1:0] map_rd_data,
   input logic              set_vld,
   input logic              set_all,
   input logic [CHW-1:0]    set_ch,
   input logic              clr_vld,
   input logic [CHW-1:0]    clr_ch,
   input logic              clr_all,
   input logic [NUM_CH-1:0] hw_req,
   input logic [NUM_CH-1:0] sw_req,
   input logic [NUM_CH-1:0] link_req,
   input logic [NUM_CH-1:0] ack,
   input logic [NUM_CH-1:0] pend,
   input logic [NUM_CH-1:0] sw_held,
   input logic [NUM_CH-1:0] link_held
);

   localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

   AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (map_rd_data == '0)); // R10

   AST_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (map_wr_en && !set_vld && !clr_vld) |=> (map_rd_data == $past(map_wr_data))); // R2

   AST_SET_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vld && !set_all && !clr_vld && !map_wr_en)
      |=> (map_rd_data == ($past(map_rd_data) | (ONE << $past(set_ch))))); // R3

   AST_CLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vld && !clr_all && !set_vld && !map_wr_en)
      |=> (map_rd_data == ($past(map_rd_data) & ~(ONE << $past(clr_ch))))); // R4

   AST_WRITE_THEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (map_wr_en && set_vld && !set_all && !clr_vld)
      |=> (map_rd_data == ($past(map_wr_data) | (ONE << $past(set_ch))))); // R5

   AST_NO_STRAY_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & ~(hw_req & map_rd_data) & ~sw_held & ~link_held) == '0)); // R6

   AST_SW_CAUGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_req != '0) |=> ((pend & $past(sw_req)) == $past(sw_req))); // R8

   AST_LINK_CAUGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (link_req != '0) |=> ((pend & $past(link_req)) == $past(link_req))); // R9

   AST_HELD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ((sw_held & ~ack) != '0) |=> ((sw_held & $past(sw_held & ~ack)) == $past(sw_held & ~ack))); // R8

endmodule

bind dma_req_gate dmagate_chk #(.NUM_CH(NUM_CH), .CHW(CHW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .map_wr_en   (map_wr_en),
   .map_wr_data (map_wr_data),
   .map_rd_data (map_rd_data),
   .set_vld     (set_vld),
   .set_all     (set_all),
   .set_ch      (set_ch),
   .clr_vld     (clr_vld),
   .clr_ch      (clr_ch),
   .clr_all     (clr_all),
   .hw_req      (hw_req),
   .sw_req      (sw_req),
   .link_req    (link_req),
   .ack         (ack),
   .pend        (pend),
   .sw_held     (sw_held),
   .link_held   (link_held)
);

// File: tb/sim_dma_req_gate.sv
module sim_dma_req_gate;

   localparam int NCH = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           map_wr_en = 1'b0;
   logic [NCH-1:0] map_wr_data = '0;
   logic [NCH-1:0] map_rd_data;
   logic           set_vld = 1'b0, set_all = 1'b0;
   logic [3:0]     set_ch = '0;
   logic           clr_vld = 1'b0, clr_all = 1'b0;
   logic [3:0]     clr_ch = '0;
   logic [NCH-1:0] hw_req = '0, sw_req = '0, link_req = '0, ack = '0;
   logic [NCH-1:0] pend;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   string tag_map = "R10";
   string tag_pnd = "R10";

   // Behavioural model state
   bit [NCH-1:0] m_en, m_sw, m_lk, m_sup;

   always #4 clk = ~clk;   // 125 MHz

   dma_req_gate #(.NUM_CH(NCH)) u0 (
      .clk(clk), .rst_n(rst_n),
      .map_wr_en(map_wr_en), .map_wr_data(map_wr_data), .map_rd_data(map_rd_data),
      .set_vld(set_vld), .set_all(set_all), .set_ch(set_ch),
      .clr_vld(clr_vld), .clr_all(clr_all), .clr_ch(clr_ch),
      .hw_req(hw_req), .sw_req(sw_req), .link_req(link_req),
      .ack(ack), .pend(pend)
   );

   task automatic chk(input string tag, input string what,
                      input logic [NCH-1:0] got, input logic [NCH-1:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, got, exp, $time);
      end
   endtask

   // Model of one clock edge, written from the requirements.
   task automatic model_edge();
      bit [NCH-1:0] nxt;
      if (!rst_n) begin
         m_en = '0; m_sw = '0; m_lk = '0; m_sup = '0;
         return;
      end
      nxt = map_wr_en ? map_wr_data : m_en;
      if (set_vld) begin
         if (set_all) nxt = '1;
         else         nxt[set_ch] = 1'b1;
      end
      if (clr_vld) begin
         if (clr_all) nxt = '0;
         else         nxt[clr_ch] = 1'b0;
      end
      m_en = nxt;
      for (int c = 0; c < NCH; c++) begin
         if (sw_req[c])        m_sw[c] = 1'b1;
         else if (ack[c])      m_sw[c] = 1'b0;
         if (link_req[c])      m_lk[c] = 1'b1;
         else if (ack[c])      m_lk[c] = 1'b0;
         if (!hw_req[c])       m_sup[c] = 1'b0;
         else if (ack[c])      m_sup[c] = 1'b1;
      end
   endtask

   // Compare before the edge, advance the model after it, drop strobes.
   task automatic step();
      @(negedge clk);
      #1;
      chk(tag_map, "map", map_rd_data, m_en);
      chk(tag_pnd, "pend", pend, (hw_req & m_en & ~m_sup) | m_sw | m_lk);
      @(posedge clk);
      #1;
      model_edge();
      map_wr_en = 1'b0; set_vld = 1'b0; set_all = 1'b0;
      clr_vld = 1'b0; clr_all = 1'b0;
      sw_req = '0; link_req = '0; ack = '0;
   endtask

   task automatic tags(input string a, input string b);
      tag_map = a; tag_pnd = b;
   endtask

   initial begin
      m_en = '0; m_sw = '0; m_lk = '0; m_sup = '0;
      tags("R10", "R10");
      hw_req = 16'hFFFF;
      repeat (3) step();
      @(negedge clk); rst_n = 1'b1;
      step();
      hw_req = '0;
      step();

      // R1: one-hot walk, bit n is channel n
      tags("R1", "R1");
      for (int c = 0; c < NCH; c++) begin
         map_wr_en = 1'b1; map_wr_data = 16'(1 << c); step();
      end
      step();

      // R2: full writes
      tags("R2", "R2");
      foreach (map_wr_data[i]) ;
      map_wr_en = 1'b1; map_wr_data = 16'hA5A5; step();
      map_wr_en = 1'b1; map_wr_data = 16'hFFFF; step();
      map_wr_en = 1'b1; map_wr_data = 16'h3C3C; step();
      map_wr_en = 1'b1; map_wr_data = 16'h0000; step();
      step();

      // R3: single set and set-all
      tags("R3", "R3");
      set_vld = 1'b1; set_ch = 4'd3;  step();
      set_vld = 1'b1; set_ch = 4'd15; step();
      set_vld = 1'b1; set_ch = 4'd0;  step();
      set_vld = 1'b1; set_all = 1'b1; step();
      step();

      // R4: single clear, clear-all, clear wins over same-channel set
      tags("R4", "R4");
      clr_vld = 1'b1; clr_ch = 4'd7; step();
      clr_vld = 1'b1; clr_ch = 4'd0; step();
      clr_vld = 1'b1; clr_all = 1'b1; step();
      set_vld = 1'b1; set_ch = 4'd9; clr_vld = 1'b1; clr_ch = 4'd9; step();
      set_vld = 1'b1; set_ch = 4'd2; clr_vld = 1'b1; clr_ch = 4'd4; step();
      step();

      // R5: full write combined with set and clear
      tags("R5", "R5");
      map_wr_en = 1'b1; map_wr_data = 16'h00F0;
      set_vld = 1'b1; set_ch = 4'd1; clr_vld = 1'b1; clr_ch = 4'd5; step();
      map_wr_en = 1'b1; map_wr_data = 16'h0F00; set_vld = 1'b1; set_all = 1'b1; step();
      map_wr_en = 1'b1; map_wr_data = 16'hFFFF; clr_vld = 1'b1; clr_ch = 4'd15; step();
      step();

      // R6: hardware gating by the enable map
      tags("R6", "R6");
      map_wr_en = 1'b1; map_wr_data = 16'h00FF; step();
      hw_req = 16'hFFFF; step();
      map_wr_en = 1'b1; map_wr_data = 16'hFF00; step();
      step();
      hw_req = 16'h0F0F; step();
      map_wr_en = 1'b1; map_wr_data = 16'h0000; step();
      step();
      hw_req = '0; step();

      // R7: ack suppresses a standing level until it drops
      tags("R7", "R7");
      map_wr_en = 1'b1; map_wr_data = 16'h0004; step();
      hw_req = 16'h0004; step();
      ack = 16'h0004; step();
      step(); step();
      hw_req = '0; step();
      hw_req = 16'h0004; step();
      step();
      hw_req = '0; step();

      // R8: software requests bypass the enable and hold until ack
      tags("R8", "R8");
      map_wr_en = 1'b1; map_wr_data = 16'h0000; step();
      sw_req = 16'h0200; step();
      step(); step();
      ack = 16'h0200; step();
      step();
      sw_req = 16'h8001; step();
      ack = 16'h8001; sw_req = 16'h0001; step();
      step();
      ack = 16'hFFFF; step();
      step();

      // R9: link requests behave the same way
      tags("R9", "R9");
      link_req = 16'h0040; step();
      step();
      ack = 16'h0040; link_req = 16'h0040; step();
      step();
      ack = 16'h0040; step();
      link_req = 16'h1000; sw_req = 16'h1000; step();
      ack = 16'h1000; step();
      step();

      // Random mix
      tags("R1", "R6");
      for (int k = 0; k < 4000; k++) begin
         map_wr_en   = ($urandom_range(0, 9) == 0);
         map_wr_data = 16'($urandom);
         set_vld     = ($urandom_range(0, 3) == 0);
         set_all     = ($urandom_range(0, 15) == 0);
         set_ch      = 4'($urandom_range(0, 3));
         clr_vld     = ($urandom_range(0, 3) == 0);
         clr_all     = ($urandom_range(0, 15) == 0);
         clr_ch      = 4'($urandom_range(0, 3));
         if ($urandom_range(0, 3) == 0) hw_req = 16'($urandom);
         sw_req      = ($urandom_range(0, 5) == 0) ? 16'($urandom & $urandom) : '0;
         link_req    = ($urandom_range(0, 5) == 0) ? 16'($urandom & $urandom) : '0;
         ack         = ($urandom_range(0, 2) == 0) ? 16'($urandom) : '0;
         step();
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule